// File: doc/BRIEF.md
# Codec Power-Down Sequencer

This block decides whether the digital core of a PCM voice codec is powered up. It watches three asynchronous inputs: a shared pin that carries either the receive master clock or a static power-down level, and the transmit and receive frame sync strobes. All three are sampled on a fast system clock. The block raises a power-up status only when the shared pin allows it and a frame sync arrives. It drops the status when the pin is held high, or when neither frame sync has produced a rising edge for a programmable number of system clocks. That count stands for an inactivity time of about two milliseconds.

Two output-enable qualifiers come from this status. The analog output qualifier follows the power state. The PCM data output qualifier waits until a second transmit frame sync has been seen after wake-up, so the serial data line does not drive stale data on the first frame. The shared pin counts as "clocked" when it has changed level within a programmable window of system clocks. In that case its level is ignored. Otherwise its synchronized static level decides.

Top module: `codec_pd_seq`

## Requirements
- R1: After reset, and with no frame sync activity, `pwr_up`, `pcm_oe` and `ana_oe` are all 0.
- R2: With the shared pin low, a transmit frame sync pulse sets `pwr_up` to 1 within 5 system clocks of the pulse start.
- R3: With the shared pin low, a receive frame sync pulse alone also sets `pwr_up` to 1.
- R4: While the shared pin is statically high, `pwr_up` is forced to 0 within 10 clocks, and frame sync pulses do not raise it.
- R5: While the shared pin toggles (one level change at least every `ACT_WINDOW` clocks), it counts as enabling, and a frame sync pulse raises `pwr_up`.
- R6: When no frame sync rising edge occurs, `pwr_up` stays 1 for at least `IDLE_CYCLES` clocks after the last detected edge, and it falls within `IDLE_CYCLES` + 8 clocks.
- R7: `pcm_oe` is 0 until the second transmit frame sync rising edge after wake-up. Receive syncs do not advance that count. The count restarts at every power-down.
- R8: `ana_oe` equals `pwr_up` at all times, and `pcm_oe` is never 1 while `pwr_up` is 0.
- R9: When a toggling pin stops at the high level, the block powers down once `ACT_WINDOW` clocks pass without a pin edge, even while frame syncs keep arriving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk_pd_pin | input | 1 | Shared receive master clock / power-down level pin (asynchronous) |
| fsync_tx | input | 1 | Transmit frame sync (asynchronous) |
| fsync_rx | input | 1 | Receive frame sync (asynchronous) |
| pwr_up | output | 1 | Core power-up status |
| pcm_oe | output | 1 | Qualifier permitting the PCM data output to drive |
| ana_oe | output | 1 | Qualifier permitting the analog output to drive |

## Verification
The bench tries every combination of the pin's three conditions (low, high, toggling) with each of the two sync sources, starting from reset each time. This shows that the pin level, not the sync source, gates wake-up. Transmit-only, receive-then-transmit and transmit-transmit sequences show that only transmit edges open the PCM data qualifier, and that a fresh wake-up restarts the count. Quiet gaps are sampled just before and well after the timeout, which separates early drop-out from a missing timeout. A pin that stops toggling in the high state, while syncs keep arriving, shows that the activity window decides power-down rather than sync presence.

// File: rtl/codec_pd_pkg.sv
package codec_pd_pkg;

  typedef enum logic [1:0] {
    TXS_NONE = 2'd0,
    TXS_ONE  = 2'd1,
    TXS_LIVE = 2'd2
  } txseen_e;

  // Next power state: pin veto first, then wake on sync, then idle drop.
  function automatic logic next_power(input logic pin_ok, input logic any_rise,
                                      input logic idle, input logic cur);
    if (!pin_ok)       return 1'b0;
    else if (any_rise) return 1'b1;
    else if (idle)     return 1'b0;
    else               return cur;
  endfunction

  // Transmit-sync tally since wake-up, saturating at TXS_LIVE.
  function automatic txseen_e next_txseen(input logic pwr_nxt, input logic tx_rise,
                                          input txseen_e cur);
    if (!pwr_nxt)                       return TXS_NONE;
    else if (tx_rise && cur == TXS_NONE) return TXS_ONE;
    else if (tx_rise && cur == TXS_ONE)  return TXS_LIVE;
    else                                 return cur;
  endfunction

endpackage

// File: rtl/cpd_sync2.sv
module cpd_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/cpd_pin_classifier.sv
module cpd_pin_classifier #(
  parameter int ACT_WINDOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  output logic pin_edge,
  output logic pin_clocked,
  output logic pin_ok
);
  localparam int AW = $clog2(ACT_WINDOW + 1);

  logic          pin_d;
  logic [AW-1:0] act_cnt;

  assign pin_edge    = pin_s ^ pin_d;
  assign pin_clocked = (act_cnt != '0);
  assign pin_ok      = pin_clocked || !pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d   <= 1'b0;
      act_cnt <= '0;
    end else begin
      pin_d <= pin_s;
      if (pin_edge)            act_cnt <= AW'(ACT_WINDOW);
      else if (act_cnt != '0)  act_cnt <= act_cnt - 1'b1;
    end
  end

  // R9: a pin edge marks the pin as clocked on the following cycle
  a_r9_edge_marks_clocked: assert property (@(posedge clk) disable iff (!rst_n)
    pin_edge |=> pin_clocked);

  // R4: a quiet pin sitting high never counts as enabling
  a_r4_quiet_high_vetoes: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_clocked && pin_s) |-> !pin_ok);
endmodule

// File: rtl/cpd_idle_timer.sv
module cpd_idle_timer #(
  parameter int IDLE_CYCLES = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic idle
);
  localparam int TW = $clog2(IDLE_CYCLES + 1);

  logic [TW-1:0] cnt;

  assign idle = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (reload)     cnt <= TW'(IDLE_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  // R6: every sync edge restarts the full inactivity window
  a_r6_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == TW'(IDLE_CYCLES)));

  // R6: the window only shrinks by one per clock without a reload
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !idle) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/codec_pd_seq.sv
module codec_pd_seq
  import codec_pd_pkg::*;
#(
  parameter int IDLE_CYCLES = 8192,
  parameter int ACT_WINDOW  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_pd_pin,
  input  logic fsync_tx,
  input  logic fsync_rx,
  output logic pwr_up,
  output logic pcm_oe,
  output logic ana_oe
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in, syn, syn_d;
  logic             tx_rise, rx_rise, any_rise;
  logic             pin_edge, pin_clocked, pin_ok, idle;
  logic             pwr_nxt;
  txseen_e          txseen, txseen_nxt;

  assign raw_in = {mclk_pd_pin, fsync_rx, fsync_tx};

  cpd_sync2 #(.W(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syn_d <= '0;
    else        syn_d <= syn;
  end

  assign tx_rise  = syn[0] && !syn_d[0];
  assign rx_rise  = syn[1] && !syn_d[1];
  assign any_rise = tx_rise || rx_rise;

  cpd_pin_classifier #(.ACT_WINDOW(ACT_WINDOW)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_s(syn[2]),
    .pin_edge(pin_edge), .pin_clocked(pin_clocked), .pin_ok(pin_ok)
  );

  cpd_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .reload(any_rise), .idle(idle)
  );

  assign pwr_nxt    = next_power(pin_ok, any_rise, idle, pwr_up);
  assign txseen_nxt = next_txseen(pwr_nxt, tx_rise, txseen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_up <= 1'b0;
      txseen <= TXS_NONE;
    end else begin
      pwr_up <= pwr_nxt;
      txseen <= txseen_nxt;
    end
  end

  assign ana_oe = pwr_up;
  assign pcm_oe = pwr_up && (txseen == TXS_LIVE);

  // R2 / R3: an enabled pin plus a sync edge wakes the core
  a_r2_wake_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_ok && any_rise) |=> pwr_up);

  // R4: a vetoing pin keeps the core down
  a_r4_pin_forces_down: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_ok |=> !pwr_up);

  // R6: a drop only follows an expired timer or a pin veto
  a_r6_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_up) |-> $past(idle || !pin_ok));

  // R7: the data qualifier opens only on a transmit edge
  a_r7_open_on_tx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_oe) |-> $past(tx_rise));

  // R8: data qualifier implies power
  a_r8_pcm_needs_pwr: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_oe |-> pwr_up);
endmodule

// File: tb/codec_pd_seq_test.sv
module codec_pd_seq_test;
  localparam int N = 40;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync_tx = 1'b0, fsync_rx = 1'b0, pin = 1'b0;
  logic pwr_up, pcm_oe, ana_oe;
  int   pin_mode = 0;  // 0 low, 1 high, 2 toggling
  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  codec_pd_seq #(.IDLE_CYCLES(N), .ACT_WINDOW(W)) uut (
    .clk(clk), .rst_n(rst_n), .mclk_pd_pin(pin),
    .fsync_tx(fsync_tx), .fsync_rx(fsync_rx),
    .pwr_up(pwr_up), .pcm_oe(pcm_oe), .ana_oe(ana_oe)
  );

  always @(negedge clk) begin
    if (pin_mode == 0)      pin <= 1'b0;
    else if (pin_mode == 1) pin <= 1'b1;
    else                    pin <= ~pin;
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // pulse of 2 clocks, then 3 idle clocks; returns 5 clocks after start
  task automatic pulse(input bit tx);
    if (tx) fsync_tx = 1'b1; else fsync_rx = 1'b1;
    cyc(2);
    fsync_tx = 1'b0; fsync_rx = 1'b0;
    cyc(3);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    cyc(10);
    chk("R1", "pwr_up", pwr_up, 1'b0);
    chk("R1", "pcm_oe", pcm_oe, 1'b0);
    chk("R1", "ana_oe", ana_oe, 1'b0);

    pulse(1);
    chk("R2", "pwr_up after tx", pwr_up, 1'b1);
    chk("R8", "ana_oe follows", ana_oe, 1'b1);
    chk("R7", "pcm_oe after 1st tx", pcm_oe, 1'b0);
    pulse(1);
    chk("R7", "pcm_oe after 2nd tx", pcm_oe, 1'b1);

    // last edge registered ~3 clocks after the pulse start; 5 already elapsed
    cyc(N - 6);
    chk("R6", "still up before timeout", pwr_up, 1'b1);
    cyc(14);
    chk("R6", "down after timeout", pwr_up, 1'b0);
    chk("R7", "pcm_oe cleared", pcm_oe, 1'b0);
    chk("R8", "ana_oe follows", ana_oe, 1'b0);

    pulse(0);
    chk("R3", "pwr_up after rx", pwr_up, 1'b1);
    chk("R7", "rx does not count", pcm_oe, 1'b0);
    pulse(1);
    chk("R7", "one tx after rx wake", pcm_oe, 1'b0);
    pulse(0);
    chk("R7", "rx between tx", pcm_oe, 1'b0);
    pulse(1);
    chk("R7", "second tx opens", pcm_oe, 1'b1);

    pin_mode = 1;
    cyc(10);
    chk("R4", "pin high forces down", pwr_up, 1'b0);
    chk("R8", "pcm_oe with power down", pcm_oe, 1'b0);
    pulse(1);
    chk("R4", "sync ignored while high", pwr_up, 1'b0);
    pulse(0);
    chk("R4", "rx ignored while high", pwr_up, 1'b0);

    pin_mode = 2;
    cyc(4);
    pulse(1);
    chk("R5", "toggling pin allows wake", pwr_up, 1'b1);
    pulse(1);
    chk("R5", "toggling pin data qualifier", pcm_oe, 1'b1);

    // stop toggling at high while syncs keep coming
    @(negedge clk);
    while (pin !== 1'b0) @(negedge clk);
    pin_mode = 1;
    cyc(1);
    chk("R9", "still up just after stop", pwr_up, 1'b1);
    for (int k = 0; k < 3; k++) pulse(k % 2);
    chk("R9", "down after window", pwr_up, 1'b0);

    // sweep: pin condition x sync source, from reset each time
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 2; s++) begin
        pin_mode = m;
        do_reset();
        cyc(10);
        chk("R1", "swept reset state", pwr_up, 1'b0);
        pulse(s[0]);
        chk(m == 1 ? "R4" : (s == 0 ? "R3" : "R2"), $sformatf("sweep m%0d s%0d", m, s),
            pwr_up, (m != 1));
        chk("R8", "sweep ana_oe", ana_oe, pwr_up);
      end
    end

    // sweep of quiet gap lengths around the timeout
    pin_mode = 0;
    do_reset();
    for (int g = 0; g < 4; g++) begin
      pulse(1);
      cyc(N - 6 - g);
      chk("R6", $sformatf("gap %0d still up", g), pwr_up, 1'b1);
    end
    cyc(N + 8);
    chk("R6", "gap sweep ends down", pwr_up, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(20000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule